// File: doc/BRIEF.md
# Redundant SAR Code Corrector

This block sits after the bit-cycle controller of a successive-approximation converter whose search uses more decision steps than output bits. The controller hands over a 13-bit vector of raw comparator decisions together with a strobe. Each decision carries a fixed weight. Some weights belong to the plain binary part of the capacitor array. The others come from pieces that were split off the most significant capacitor. The block forms the weighted sum of the decisions and returns a 10-bit binary code.

The correction uses additions only. The weights are restricted so that their total is exactly 1023, which means the sum can never leave the 10-bit range. No subtraction, offset removal or clipping is needed. Because the search is redundant, one missed step early in a conversion is absorbed by the later steps, and the same code comes out.

A single-bit table check runs at elaboration and stops the build if the weight parameter breaks a rule. The output stage is a two-state machine, EMPTY and FULL. The transition EMPTY→FULL takes place on an accepted strobe. FULL→FULL takes place on a back-to-back strobe. FULL→EMPTY and EMPTY→EMPTY take place when no strobe is present.

Top module: `redund_code_fixer`

## Requirements
- R1: The code equals the sum of the weights of the set raw bits. By raw bit index 12 down to 0, the default weights are 256, 256, 136, 128, 96, 64, 32, 24, 16, 8, 4, 2, 1. Bit 12 is the first decision.
- R2: A result appears one clock after its strobe is sampled. code_valid is high in that cycle and code holds the result.
- R3: The raw vector with all bits set gives 1023, and no raw vector gives a sum above 1023.
- R4: The raw vector with all bits clear gives code 0.
- R5: While raw_valid is low, raw_bits has no effect. In the following cycle code_valid is low and code keeps its previous value.
- R6: For every level 0..1023, the error-free greedy search pattern corrects to that level.
- R7: A search pattern that missed one step still corrects to the true level. Such a step is one where the residual reached the step weight but stayed within the sum of the remaining weights, and the decision came out 0.
- R8: Strobes on consecutive cycles each give a result on consecutive cycles, in order.
- R9: After reset, code_valid is low and code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_valid | input | 1 | Raw decision vector is present |
| raw_bits | input | 13 | Raw decisions, bit 12 first |
| code_valid | output | 1 | Corrected code is present |
| code | output | 10 | Corrected binary code |

## Verification
All 8192 raw vectors are applied and compared with a weight sum computed in the bench. This shows whether every weight lands on the right column. Ideal search patterns for all 1024 levels show that the weight table reconstructs every level. Patterns with one injected missed step, at each recoverable position, show that a wrong early decision is repaired and not passed through as an offset. Idle cycles with a changing raw vector, placed between results, show that an unstrobed vector cannot disturb the held code.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } ostate_e;

    function automatic int unsigned ones_in(input logic [31:0] x);
        int unsigned n;
        n = 0;
        for (int b = 0; b < 32; b++) begin
            n += int'(x[b]);
        end
        return n;
    endfunction

endpackage

// File: rtl/rdc_row_gate.sv
module rdc_row_gate #(
    parameter int          NOUT   = 10,
    parameter logic [NOUT-1:0] WEIGHT = '0
) (
    input  logic            bit_in,
    output logic [NOUT-1:0] row
);
    always_comb begin
        row = bit_in ? WEIGHT : '0;
    end
endmodule

// File: rtl/rdc_sum_tree.sv
module rdc_sum_tree #(
    parameter int NRAW = 13,
    parameter int NOUT = 10,
    parameter int SUMW = 14
) (
    input  logic [NRAW*NOUT-1:0] rows,
    output logic [SUMW-1:0]      sum
);
    logic [SUMW-1:0] partial [0:NRAW];

    assign partial[0] = '0;

    for (genvar i = 0; i < NRAW; i++) begin : g_acc
        assign partial[i+1] = partial[i] + {{(SUMW-NOUT){1'b0}}, rows[i*NOUT +: NOUT]};
    end

    assign sum = partial[NRAW];
endmodule

// File: rtl/rdc_out_stage.sv
module rdc_out_stage
    import rdc_pkg::*;
#(
    parameter int NOUT       = 10,
    parameter bit REGISTERED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [NOUT-1:0] in_code,
    output logic            out_valid,
    output logic [NOUT-1:0] out_code
);
    if (REGISTERED) begin : g_reg
        ostate_e         state_q;
        ostate_e         state_d;
        logic [NOUT-1:0] code_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q <= OS_EMPTY;
            end else begin
                state_q <= state_d;
            end
        end

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                OS_EMPTY: state_d = in_valid ? OS_FULL : OS_EMPTY;
                OS_FULL:  state_d = in_valid ? OS_FULL : OS_EMPTY;
                default:  state_d = OS_EMPTY;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q <= '0;
            end else if (in_valid) begin
                code_q <= in_code;
            end
        end

        always_comb begin
            out_valid = (state_q == OS_FULL);
            out_code  = code_q;
        end

        // R2
        valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (out_valid == $past(in_valid)));

        // R2
        code_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_code == $past(in_code)));

        // R5
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(out_code) && !out_valid));
    end else begin : g_comb
        always_comb begin
            out_valid = in_valid;
            out_code  = in_code;
        end
    end
endmodule

// File: rtl/redund_code_fixer.sv
module redund_code_fixer #(
    parameter int NRAW       = 13,
    parameter int NOUT       = 10,
    parameter bit REGISTERED = 1'b1,
    parameter logic [NRAW*NOUT-1:0] WEIGHTS = {
        10'd256, 10'd256, 10'd136, 10'd128, 10'd96, 10'd64, 10'd32,
        10'd24,  10'd16,  10'd8,   10'd4,   10'd2,  10'd1 }
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_valid,
    input  logic [12:0]     raw_bits,
    output logic            code_valid,
    output logic [9:0]      code
);
    localparam int SUMW     = NOUT + $clog2(NRAW + 1);
    localparam int FULL_VAL = (1 << NOUT) - 1;

    function automatic bit table_ok();
        int unsigned total;
        int unsigned rest;
        int unsigned w;
        int unsigned cnt [NOUT];
        int unsigned triples;
        bit          ok;
        ok      = 1'b1;
        total   = 0;
        triples = 0;
        for (int b = 0; b < NOUT; b++) cnt[b] = 0;
        for (int i = 0; i < NRAW; i++) begin
            w = int'(WEIGHTS[i*NOUT +: NOUT]);
            if (w == 0 || rdc_pkg::ones_in(32'(w)) > 2) ok = 1'b0;
            total += w;
            for (int b = 0; b < NOUT; b++) cnt[b] += int'(WEIGHTS[i*NOUT + b]);
            rest = 0;
            for (int j = 0; j < i; j++) rest += int'(WEIGHTS[j*NOUT +: NOUT]);
            if (w > rest + 1) ok = 1'b0;
        end
        for (int b = 0; b < NOUT; b++) begin
            if (cnt[b] > 3) ok = 1'b0;
            if (cnt[b] == 3) triples++;
        end
        if (triples > 1) ok = 1'b0;
        if (total != FULL_VAL) ok = 1'b0;
        return ok;
    endfunction

    localparam bit TABLE_OK = table_ok();

    if (!TABLE_OK) begin : g_bad_table
        $error("redund_code_fixer: weight table violates column, total or redundancy rule");
    end

    logic [NRAW*NOUT-1:0] rows;
    logic [SUMW-1:0]      wide_sum;

    for (genvar i = 0; i < NRAW; i++) begin : g_rows
        rdc_row_gate #(
            .NOUT   (NOUT),
            .WEIGHT (WEIGHTS[i*NOUT +: NOUT])
        ) row_i (
            .bit_in (raw_bits[i]),
            .row    (rows[i*NOUT +: NOUT])
        );
    end

    rdc_sum_tree #(
        .NRAW (NRAW),
        .NOUT (NOUT),
        .SUMW (SUMW)
    ) sum_i (
        .rows (rows),
        .sum  (wide_sum)
    );

    rdc_out_stage #(
        .NOUT       (NOUT),
        .REGISTERED (REGISTERED)
    ) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (raw_valid),
        .in_code   (wide_sum[NOUT-1:0]),
        .out_valid (code_valid),
        .out_code  (code)
    );

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |-> (wide_sum <= SUMW'(FULL_VAL)));

    // R3
    full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_valid && (&raw_bits)) |-> (wide_sum == SUMW'(FULL_VAL)));

    // R4
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_valid && (raw_bits == '0)) |-> (wide_sum == '0));
endmodule

// File: tb/redund_code_fixer_tb_top.sv
module redund_code_fixer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raw_valid = 1'b0;
    logic [12:0] raw_bits = '0;
    logic        code_valid;
    logic [9:0]  code;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    int    exp_q [$];
    string tag_q [$];
    int    last_exp = 0;

    // weights by raw bit index 0..12 (R1)
    localparam int W [13] = '{1, 2, 4, 8, 16, 24, 32, 64, 96, 128, 136, 256, 256};

    always #5 clk = ~clk;

    redund_code_fixer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_valid  (raw_valid),
        .raw_bits   (raw_bits),
        .code_valid (code_valid),
        .code       (code)
    );

    function automatic int weight_sum(input logic [12:0] p);
        int s;
        s = 0;
        for (int i = 0; i < 13; i++) if (p[i]) s += W[i];
        return s;
    endfunction

    // greedy redundant search; errstep < 0 means no error injected
    function automatic logic [12:0] search(input int v, input int errstep, output bit ok);
        logic [12:0] p;
        int acc;
        int rest;
        p   = '0;
        acc = 0;
        ok  = (errstep < 0);
        for (int i = 12; i >= 0; i--) begin
            rest = 0;
            for (int j = 0; j < i; j++) rest += W[j];
            if (i == errstep && (v - acc) >= W[i] && (v - acc) <= rest) begin
                p[i] = 1'b0;
                ok   = 1'b1;
            end else if ((v - acc) >= W[i]) begin
                p[i] = 1'b1;
                acc += W[i];
            end
        end
        return p;
    endfunction

    task automatic drive(input logic [12:0] p, input int e, input string tag);
        @(negedge clk);
        raw_valid = 1'b1;
        raw_bits  = p;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_exp = e;
    endtask

    task automatic idle_check(input logic [12:0] p, input string tag);
        @(negedge clk);
        raw_valid = 1'b0;
        raw_bits  = p;
        @(negedge clk);
        vectors++;
        if (code_valid !== 1'b0 || int'(code) != last_exp) begin
            miscompares++;
            $display("FAIL %s: valid=%0b code=%0d expected valid=0 code=%0d",
                     tag, code_valid, code, last_exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && code_valid) begin
            if (exp_q.size() == 0) begin
                vectors++;
                miscompares++;
                $display("FAIL R2: unexpected result code=%0d expected no result", code);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                vectors++;
                if (int'(code) != e) begin
                    miscompares++;
                    $display("FAIL %s: code=%0d expected=%0d", t, code, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        vectors++;
        if (code_valid !== 1'b0 || code !== 10'd0) begin
            miscompares++;
            $display("FAIL R9: valid=%0b code=%0d expected valid=0 code=0", code_valid, code);
        end

        // R4 and R3 corner vectors
        drive(13'h0000, 0, "R4");
        idle_check(13'h1FFF, "R5");
        drive(13'h1FFF, 1023, "R3");
        idle_check(13'h0000, "R5");

        // R1 and R8: every raw vector back to back
        for (int p = 0; p < 8192; p++) begin
            drive(13'(p), weight_sum(13'(p)), "R1/R8");
        end
        idle_check(13'h0AAA, "R5");

        // R6 ideal search for every level
        for (int v = 0; v < 1024; v++) begin
            bit ok;
            logic [12:0] p;
            p = search(v, -1, ok);
            drive(p, v, "R6");
        end
        idle_check(13'h1555, "R5");

        // R7 one missed step at each recoverable position
        for (int v = 0; v < 1024; v++) begin
            for (int s = 0; s < 13; s++) begin
                bit ok;
                logic [12:0] p;
                p = search(v, s, ok);
                if (ok) drive(p, v, "R7");
            end
        end
        idle_check(13'h0F0F, "R5");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            vectors++;
            miscompares++;
            $display("FAIL R8: %0d results missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule